// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two eight-bit bidirectional buses, A and B. Each direction has its own capture register, clocked by its own clock. Every rising edge of that clock stores whatever the source bus carries at the pin. A capture is never held off by the output enables. It still happens when the block itself is driving that bus.

For each direction, a select chooses what the outgoing bus carries. One setting passes the opposite bus through live. The other setting drives the value held in that direction's register.

Two enables of opposite polarity control the output drivers:

- The enable for bus B is active high.
- The enable for bus A is active low.

Each tristate bus is modelled at the block edge as three vectors: an input, an output value and a per-bit output enable. A resolver in the testbench combines them into the wire value. The enable pins are decoded into one of four drive modes: ISOLATE, DRIVE_B, DRIVE_A and DRIVE_BOTH. Selects and enables act combinationally, so only the two capture registers hold state.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: On every rising edge of `clk_ab`, the A register stores all bits of `a_in`. This happens whatever the enables are, including while bus A is driven by the block.
- R2: On every rising edge of `clk_ba`, the B register stores all bits of `b_in`. This happens whatever the enables are, including while bus B is driven by the block.
- R3: With `sel_ab` = 0, `b_out` equals the live `a_in`. With `sel_ab` = 1, `b_out` equals the stored A register.
- R4: With `sel_ba` = 0, `a_out` equals the live `b_in`. With `sel_ba` = 1, `a_out` equals the stored B register.
- R5: `en_ab` is active high. At 1, every bit of `b_oe` is 1. At 0, every bit of `b_oe` is 0.
- R6: `en_ba_n` is active low. At 0, every bit of `a_oe` is 1. At 1, every bit of `a_oe` is 0.
- R7: With `en_ab` = 1, `en_ba_n` = 0 and both selects at 1, both buses are driven at once. Bus B carries the stored A value and bus A carries the stored B value.
- R8: With `en_ab` = 0 and `en_ba_n` = 1, neither bus is driven. Clock edges still load the registers, and with no edges the registers keep their values.
- R9: While bus B is driven with live A data, a `clk_ba` edge loads that A value into the B register. A later `clk_ab` edge puts the same value in both registers.
- R10: While `rst_n` = 0, both registers are asynchronously cleared to zero. The output enables still follow only `en_ab` and `en_ba_n`.
- R11: A change of a select or an enable changes the outputs in the same step, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| clk_ab | input | 1 | Rising-edge capture clock for the A register |
| clk_ba | input | 1 | Rising-edge capture clock for the B register |
| sel_ab | input | 1 | Bus B source: 0 live bus A, 1 stored A register |
| sel_ba | input | 1 | Bus A source: 0 live bus B, 1 stored B register |
| en_ab | input | 1 | Active-high drive enable for bus B |
| en_ba_n | input | 1 | Active-low drive enable for bus A |
| a_in | input | W | Value seen at the bus A pins |
| a_out | output | W | Value the block drives onto bus A |
| a_oe | output | W | Per-bit drive enable for bus A |
| b_in | input | W | Value seen at the bus B pins |
| b_out | output | W | Value the block drives onto bus B |
| b_oe | output | W | Per-bit drive enable for bus B |

## Verification
Select, enable and live pass-through results are due in the same step as the stimulus, with no clock edge in between. A register result shows up only after the one rising capture edge in that step. The bench applies inputs at the start of each step and raises any requested capture clock a quarter step later. It samples the resolved buses three quarters into the step, when both kinds of result have settled and no edge is near. Edges whose order matters are placed in separate steps.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // Which of the two buses the block currently drives
    typedef enum logic [1:0] {
        MODE_ISOLATE    = 2'd0,
        MODE_DRIVE_B    = 2'd1,
        MODE_DRIVE_A    = 2'd2,
        MODE_DRIVE_BOTH = 2'd3
    } xcvr_mode_e;

    // en_ab is active high, en_ba_n is active low
    function automatic xcvr_mode_e mode_of(input logic en_ab, input logic en_ba_n);
        xcvr_mode_e m;
        if (en_ab)
            m = en_ba_n ? MODE_DRIVE_B : MODE_DRIVE_BOTH;
        else
            m = en_ba_n ? MODE_ISOLATE : MODE_DRIVE_A;
        return m;
    endfunction

endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Capture is unconditional: no enable gates the edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

endmodule

// File: rtl/xcvr_mode_decode.sv
module xcvr_mode_decode
    import xcvr_pkg::*;
(
    input  logic en_ab,
    input  logic en_ba_n,
    output logic drive_a,
    output logic drive_b
);

    xcvr_mode_e mode;

    always_comb begin
        mode = mode_of(en_ab, en_ba_n);
    end

    always_comb begin
        drive_a = 1'b0;
        drive_b = 1'b0;
        unique case (mode)
            MODE_ISOLATE: begin
                drive_a = 1'b0;
                drive_b = 1'b0;
            end
            MODE_DRIVE_B: begin
                drive_a = 1'b0;
                drive_b = 1'b1;
            end
            MODE_DRIVE_A: begin
                drive_a = 1'b1;
                drive_b = 1'b0;
            end
            MODE_DRIVE_BOTH: begin
                drive_a = 1'b1;
                drive_b = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/xcvr_out_path.sv
module xcvr_out_path #(
    parameter int W = 8
) (
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    input  logic         sel,
    input  logic         enable,
    output logic [W-1:0] dout,
    output logic [W-1:0] oe
);

    // sel = 0 passes the opposite bus through, sel = 1 drives the register
    always_comb begin
        dout = sel ? stored : live;
    end

    for (genvar i = 0; i < W; i++) begin : g_oe
        assign oe[i] = enable;
    end

endmodule

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr #(
    parameter int W = 8
) (
    input  logic         rst_n,
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic         en_ab,
    input  logic         en_ba_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe
);

    logic [W-1:0] a_q;
    logic [W-1:0] b_q;
    logic         drive_a;
    logic         drive_b;

    xcvr_capture_reg #(.W(W)) u_reg_a (
        .clk   (clk_ab),
        .rst_n (rst_n),
        .d     (a_in),
        .q     (a_q)
    );

    xcvr_capture_reg #(.W(W)) u_reg_b (
        .clk   (clk_ba),
        .rst_n (rst_n),
        .d     (b_in),
        .q     (b_q)
    );

    xcvr_mode_decode u_mode (
        .en_ab   (en_ab),
        .en_ba_n (en_ba_n),
        .drive_a (drive_a),
        .drive_b (drive_b)
    );

    xcvr_out_path #(.W(W)) u_path_b (
        .live   (a_in),
        .stored (a_q),
        .sel    (sel_ab),
        .enable (drive_b),
        .dout   (b_out),
        .oe     (b_oe)
    );

    xcvr_out_path #(.W(W)) u_path_a (
        .live   (b_in),
        .stored (b_q),
        .sel    (sel_ba),
        .enable (drive_a),
        .dout   (a_out),
        .oe     (a_oe)
    );

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
    parameter int W = 8
) (
    input logic         rst_n,
    input logic         clk_ab,
    input logic         clk_ba,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic         en_ab,
    input logic         en_ba_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic [W-1:0] a_oe,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic [W-1:0] b_oe
);

    AST_CAPTURE_A: assert property (@(posedge clk_ab) disable iff (!rst_n)
        1'b1 |=> (!(en_ab && sel_ab) || b_out == $past(a_in))); // R1

    AST_CAPTURE_B: assert property (@(posedge clk_ba) disable iff (!rst_n)
        1'b1 |=> (en_ba_n || !sel_ba || a_out == $past(b_in))); // R2

    AST_LIVE_TO_B: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (en_ab && !sel_ab) |-> b_out == a_in); // R3

    AST_LIVE_TO_A: assert property (@(posedge clk_ba) disable iff (!rst_n)
        (!en_ba_n && !sel_ba) |-> a_out == b_in); // R4

    AST_B_DRIVE_ON: assert property (@(posedge clk_ab) disable iff (!rst_n)
        en_ab |-> b_oe == {W{1'b1}}); // R5

    AST_B_DRIVE_OFF: assert property (@(posedge clk_ab) disable iff (!rst_n)
        !en_ab |-> b_oe == '0); // R5

    AST_A_DRIVE_ON: assert property (@(posedge clk_ba) disable iff (!rst_n)
        !en_ba_n |-> a_oe == {W{1'b1}}); // R6

    AST_A_DRIVE_OFF: assert property (@(posedge clk_ba) disable iff (!rst_n)
        en_ba_n |-> a_oe == '0); // R6

endmodule

bind bidir_reg_xcvr xcvr_checker #(.W(W)) u_chk (
    .rst_n   (rst_n),
    .clk_ab  (clk_ab),
    .clk_ba  (clk_ba),
    .sel_ab  (sel_ab),
    .sel_ba  (sel_ba),
    .en_ab   (en_ab),
    .en_ba_n (en_ba_n),
    .a_in    (a_in),
    .a_out   (a_out),
    .a_oe    (a_oe),
    .b_in    (b_in),
    .b_out   (b_out),
    .b_oe    (b_oe)
);

// File: tb/sim_bidir_reg_xcvr.sv
module sim_bidir_reg_xcvr;

    localparam int W      = 8;
    localparam int PERIOD = 20;
    localparam int QTR    = PERIOD / 4;
    localparam int WDOG   = 5000;

    typedef struct {
        string        tag;
        logic [W-1:0] bus_a;
        logic [W-1:0] bus_b;
        logic [W-1:0] oe_a;
        logic [W-1:0] oe_b;
    } exp_t;

    logic         tck = 1'b0;
    logic         rst_n = 1'b0;
    logic         clk_ab = 1'b0;
    logic         clk_ba = 1'b0;
    logic         sel_ab = 1'b0;
    logic         sel_ba = 1'b0;
    logic         en_ab = 1'b0;
    logic         en_ba_n = 1'b1;
    logic [W-1:0] ext_a = '0;
    logic [W-1:0] ext_b = '0;
    logic         ext_a_en = 1'b1;
    logic         ext_b_en = 1'b1;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;
    wire  [W-1:0] bus_a, bus_b;

    // Reference state of the two registers, kept from the requirements
    logic [W-1:0] m_a = '0;
    logic [W-1:0] m_b = '0;

    exp_t q[$];
    event ev_sample;
    int   n_cmp = 0;
    int   n_bad = 0;
    int   cyc   = 0;
    bit   done  = 1'b0;

    always #(PERIOD/2) tck = ~tck;

    // Bus resolvers: block drive wins where enabled, otherwise the external driver
    for (genvar i = 0; i < W; i++) begin : g_res
        assign #1 bus_a[i] = a_oe[i] ? a_out[i] : (ext_a_en ? ext_a[i] : 1'bz);
        assign #1 bus_b[i] = b_oe[i] ? b_out[i] : (ext_b_en ? ext_b[i] : 1'bz);
    end

    bidir_reg_xcvr #(.W(W)) u0 (
        .rst_n   (rst_n),
        .clk_ab  (clk_ab),
        .clk_ba  (clk_ba),
        .sel_ab  (sel_ab),
        .sel_ba  (sel_ba),
        .en_ab   (en_ab),
        .en_ba_n (en_ba_n),
        .a_in    (bus_a),
        .a_out   (a_out),
        .a_oe    (a_oe),
        .b_in    (bus_b),
        .b_out   (b_out),
        .b_oe    (b_oe)
    );

    // Expected bus values from the model registers and current controls
    task automatic model_bus(output logic [W-1:0] ea, output logic [W-1:0] eb);
        if (en_ba_n) begin
            ea = ext_a;
            eb = en_ab ? (sel_ab ? m_a : ea) : ext_b;
        end else if (!en_ab) begin
            eb = ext_b;
            ea = sel_ba ? m_b : eb;
        end else begin
            ea = sel_ba ? m_b : m_a;
            eb = sel_ab ? m_a : ea;
        end
    endtask

    task automatic push_exp(input string tag);
        exp_t e;
        logic [W-1:0] ea, eb;
        model_bus(ea, eb);
        e.tag   = tag;
        e.bus_a = ea;
        e.bus_b = eb;
        e.oe_a  = {W{~en_ba_n}};
        e.oe_b  = {W{en_ab}};
        q.push_back(e);
        -> ev_sample;
    endtask

    task automatic step(input string tag, input bit e_ab, input bit e_ba_n,
                        input bit s_ab, input bit s_ba,
                        input logic [W-1:0] xa, input logic [W-1:0] xb,
                        input bit p_ab, input bit p_ba);
        logic [W-1:0] ea, eb;
        @(posedge tck);
        en_ab    = e_ab;
        en_ba_n  = e_ba_n;
        sel_ab   = s_ab;
        sel_ba   = s_ba;
        ext_a    = xa;
        ext_b    = xb;
        ext_a_en = e_ba_n;
        ext_b_en = !e_ab;
        #(QTR);
        model_bus(ea, eb);
        if (p_ab) m_a = ea;
        if (p_ba) m_b = eb;
        clk_ab = p_ab;
        clk_ba = p_ba;
        #(QTR);
        clk_ab = 1'b0;
        clk_ba = 1'b0;
        #(QTR);
        push_exp(tag);
    endtask

    task automatic reset_step(input string tag, input bit e_ab, input bit e_ba_n,
                              input bit s_ab, input bit s_ba);
        @(posedge tck);
        en_ab    = e_ab;
        en_ba_n  = e_ba_n;
        sel_ab   = s_ab;
        sel_ba   = s_ba;
        ext_a_en = e_ba_n;
        ext_b_en = !e_ab;
        rst_n    = 1'b0;
        m_a      = '0;
        m_b      = '0;
        #(3*QTR);
        push_exp(tag);
        #(QTR/2);
        rst_n = 1'b1;
    endtask

    // Monitor: pops expected items and compares with the resolved buses
    initial begin
        forever begin
            @(ev_sample);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_cmp++;
                if (bus_a !== e.bus_a) begin
                    n_bad++;
                    $display("FAIL %s bus A: got %h expected %h", e.tag, bus_a, e.bus_a);
                end
                n_cmp++;
                if (bus_b !== e.bus_b) begin
                    n_bad++;
                    $display("FAIL %s bus B: got %h expected %h", e.tag, bus_b, e.bus_b);
                end
                n_cmp++;
                if (a_oe !== e.oe_a || b_oe !== e.oe_b) begin
                    n_bad++;
                    $display("FAIL %s drive enables: got %h/%h expected %h/%h",
                             e.tag, a_oe, b_oe, e.oe_a, e.oe_b);
                end
                n_cmp++;
                if ((ext_a_en && |a_oe) || (ext_b_en && |b_oe)) begin
                    n_bad++;
                    $display("FAIL %s contention: a_oe %h b_oe %h expected %h/%h",
                             e.tag, a_oe, b_oe, {W{1'b0}}, {W{1'b0}});
                end
            end
        end
    end

    always @(posedge tck) begin
        cyc <= cyc + 1;
        if (cyc > WDOG && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected below %0d", cyc, WDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        ext_a = 8'h5A;
        // R10: reset clears registers; bus B driven with stored A = 0, enables unaffected
        reset_step("R10 reset, B driven", 1'b1, 1'b1, 1'b1, 1'b0);

        // R8: isolation, both clocks load together
        step("R8 isolate load", 1'b0, 1'b1, 1'b0, 1'b0, 8'h3C, 8'hC3, 1'b1, 1'b1);
        step("R8 isolate hold", 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'hFF, 1'b0, 1'b0);
        // R3 / R1: stored A (3C) on B
        step("R3 stored A to B", 1'b1, 1'b1, 1'b1, 1'b0, 8'h11, 8'h00, 1'b0, 1'b0);
        // R11 / R3: select change switches with no clock
        step("R11 R3 live A to B", 1'b1, 1'b1, 1'b0, 1'b0, 8'h11, 8'h00, 1'b0, 1'b0);
        // R5: B enable off
        step("R5 B released", 1'b0, 1'b1, 1'b0, 1'b0, 8'h11, 8'h66, 1'b0, 1'b0);
        // R6 / R4 / R2: stored B (C3) on A
        step("R6 R4 stored B to A", 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h77, 1'b0, 1'b0);
        step("R11 R4 live B to A", 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h77, 1'b0, 1'b0);
        step("R2 capture B", 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h99, 1'b0, 1'b1);
        step("R2 stored B check", 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h12, 1'b0, 1'b0);
        // R7: both buses driven from the registers
        step("R7 both driven", 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0);

        // R9: live A onto B, B register captures it, then A register
        step("R9 load B from A", 1'b1, 1'b1, 1'b0, 1'b0, 8'hA5, 8'h00, 1'b0, 1'b1);
        step("R9 load A", 1'b1, 1'b1, 1'b0, 1'b0, 8'hA5, 8'h00, 1'b1, 1'b0);
        step("R9 both regs", 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0);

        // R1: capture of bus A while the block drives it with stored B
        step("R1 set B reg", 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'hE1, 1'b0, 1'b1);
        step("R1 capture driven A", 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 1'b1, 1'b0);
        step("R1 stored A check", 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0);

        // R1 / R2: pattern sweep, capture in isolation and read both back
        for (int i = 0; i < 16; i++) begin
            logic [W-1:0] pa, pb;
            pa = W'(i * 37 + 5);
            pb = W'(i * 91 + 200);
            step("R8 sweep load", 1'b0, 1'b1, 1'b0, 1'b0, pa, pb, 1'b1, 1'b1);
            step("R1 R2 sweep read", 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0);
        end

        // R10: reset mid-run while A is driven with stored B
        reset_step("R10 reset, A driven", 1'b0, 1'b0, 1'b0, 1'b1);
        step("R10 after reset", 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0);

        @(posedge tck);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule